// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block lets on-chip logic read and write 16-bit registers in an external Ethernet PHY over the two-wire management bus. The bus has a clock and one shared data line, which appears here as an output, an output enable and an input. The host drives a one-cycle command strobe together with a direction select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It then waits for a one-cycle done pulse. Read data appears on a 16-bit output and holds until a later read completes.

Each frame starts with a preamble of ones. The start and opcode fields follow, then the two address fields. Writes add a driven turnaround and the data. Reads instead release the line for a turnaround pulse and then sample 16 bits from the PHY. All timing is counted in phases, and each phase lasts `PHASE_CLKS` system clocks. The default of 10 keeps the management clock at or below 2.5 MHz from a 50 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, busy_o, done_o, mdc_o and mdio_oe_o are all 0.
- R2: A frame drives 32 one bits first. It then drives the start field 01 and the opcode, which is 10 when rd_i=1 (read) and 01 when rd_i=0 (write). All fields go out MSB first.
- R3: After the opcode, the 5-bit PHY address is driven, then the 5-bit register address, each MSB first.
- R4: Every driven bit takes three phases of PHASE_CLKS system clocks each: clock low, then clock high, then clock low. The data line holds the bit for all three phases.
- R5: A write then drives the turnaround bits 10 and the 16 data bits MSB first. It ends with one phase with the line released and the clock low.
- R6: A read releases the line after the register address. It then gives one turnaround clock pulse of three phases: low, high, low.
- R7: A read then runs 16 cycles, each a high phase followed by a low phase. mdio_i is sampled on the last system clock of each high phase, and the bits assemble MSB first into rdata_o.
- R8: mdio_oe_o is 1 for every driven field and 0 for the whole read turnaround and read data phase.
- R9: A cmd_i strobe that arrives while busy_o=1 is ignored, and the frame in progress continues unchanged.
- R10: done_o is high for exactly one cycle. That cycle is the first one with busy_o=0 after the frame. rdata_o changes only in the done cycle of a read and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Command strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench tries writes with alternating data and addresses, all-zero data, and all-one data, so that a field that is swapped, shortened or sent LSB first shows up as a wrong level on the data line. Reads return 8001, 5A3C, FFFF and 0000 in hex. During each read data cycle, the bench model drives the bit during the high phase and its complement during the low phase. Sampling in the wrong phase, or on the wrong clock of a phase, therefore gives a visibly different result. A command issued mid-frame checks that strobes during a frame are ignored. A read issued in the very done cycle of the previous frame checks that a new frame is accepted back to back.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;

  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_TA,
    ST_READ,
    ST_REL
  } mdio_state_e;
endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int PHASE_CLKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic phase_end_o
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !run_i)        cnt_q <= '0;
    else if (cnt_q == LAST)          cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign phase_end_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              phase_end_i,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              oe_o,
  output logic              mdo_o,
  output logic              sample_o,
  output logic              finish_o,
  output logic              rd_frame_o
);
  localparam int HDR_W   = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int FRAME_W = HDR_W + 2 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mdio_state_e        state_q;
  logic [1:0]         ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               rd_q;
  logic [CNT_W-1:0]   drv_last;

  assign drv_last = rd_q ? RD_LAST : WR_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      sr_q    <= '0;
      rd_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_DRIVE;
          ph_q    <= '0;
          cnt_q   <= '0;
          rd_q    <= rd_i;
          sr_q    <= {{PRE_LEN{1'b1}}, START_BITS, (rd_i ? OP_READ : OP_WRITE),
                      phy_addr_i, reg_addr_i, TA_WRITE, wdata_i};
        end
        ST_DRIVE: if (phase_end_i) begin
          if (ph_q == 2'd2) begin
            ph_q <= '0;
            sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
            if (cnt_q == drv_last) begin
              cnt_q   <= '0;
              state_q <= rd_q ? ST_TA : ST_REL;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_TA: if (phase_end_i) begin
          if (ph_q == 2'd2) begin
            ph_q    <= '0;
            state_q <= ST_READ;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_READ: if (phase_end_i) begin
          if (ph_q == 2'd0) begin
            ph_q <= 2'd1;
          end else begin
            ph_q <= '0;
            if (cnt_q == DATA_LAST) state_q <= ST_IDLE;
            else                    cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_REL: if (phase_end_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  // high phase is phase 1 of driven/turnaround bits, phase 0 of read bits
  assign mdc_o      = (((state_q == ST_DRIVE) || (state_q == ST_TA)) && (ph_q == 2'd1))
                   || ((state_q == ST_READ) && (ph_q == 2'd0));
  assign oe_o       = (state_q == ST_DRIVE);
  assign mdo_o      = (state_q == ST_DRIVE) ? sr_q[FRAME_W-1] : 1'b0;
  assign sample_o   = (state_q == ST_READ) && (ph_q == 2'd0) && phase_end_i;
  assign finish_o   = phase_end_i && ((state_q == ST_REL) ||
                      ((state_q == ST_READ) && (ph_q == 2'd1) && (cnt_q == DATA_LAST)));
  assign rd_frame_o = rd_q;
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      rdata_o <= '0;
    end else begin
      if (sample_i) shift_q <= {shift_q[DATA_W-2:0], bit_i};
      if (commit_i) rdata_o <= shift_q;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHASE_CLKS = 10,
  parameter int PRE_LEN    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic accept, phase_end, sample, finish, rd_frame;

  assign accept = cmd_i && !busy_o;

  mdio_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .run_i       (busy_o),
    .phase_end_o (phase_end)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .rd_i        (rd_i),
    .phy_addr_i  (phy_addr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_i     (wdata_i),
    .phase_end_i (phase_end),
    .busy_o      (busy_o),
    .mdc_o       (mdc_o),
    .oe_o        (mdio_oe_o),
    .mdo_o       (mdio_o),
    .sample_o    (sample),
    .finish_o    (finish),
    .rd_frame_o  (rd_frame)
  );

  mdio_rx_capture u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .bit_i    (mdio_i),
    .commit_i (finish && rd_frame),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= finish;
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R4
  bit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && mdc_o) |-> $stable(mdio_o));

  // R8
  oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy_o);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(rdata_o)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rdata_o   (rdata_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_i = 1'b0, rd_i = 1'b0, mdio_i = 1'b1;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mdio_master #(.PHASE_CLKS(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  typedef struct {
    logic busy, done, mdc, oe, mdo, din, upd;
    logic [15:0] rv;
    int req;
  } exp_t;

  exp_t q[$];
  logic [15:0] cur_rd = '0;

  task automatic push(logic busy, logic done, logic mdc, logic oe, logic mdo,
                      logic din, int req, logic upd, logic [15:0] rv);
    exp_t e;
    e.busy = busy; e.done = done; e.mdc = mdc; e.oe = oe; e.mdo = mdo;
    e.din = din; e.req = req; e.upd = upd; e.rv = rv;
    q.push_back(e);
  endtask

  task automatic build(logic rd, logic [4:0] phy, logic [4:0] rg,
                       logic [15:0] wd, logic [15:0] rv);
    logic [63:0] fr;
    int nbits;
    int req;
    fr = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
    nbits = rd ? 46 : 64;
    for (int i = 0; i < nbits; i++) begin
      if (i < 36)      req = 2;  // R2 preamble, start, opcode
      else if (i < 46) req = 3;  // R3 addresses
      else             req = 5;  // R5 write turnaround and data
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < D; k++)  // R4 three phases per bit
          push(1, 0, p == 1, 1, fr[63-i], 1, req, 0, '0);
    end
    if (rd) begin
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < D; k++)  // R6 released turnaround pulse, R8
          push(1, 0, p == 1, 0, 0, 1, 6, 0, '0);
      for (int b = 15; b >= 0; b--) begin
        for (int k = 0; k < D; k++)  // R7 high phase carries the bit
          push(1, 0, 1, 0, 0, rv[b], 7, 0, '0);
        for (int k = 0; k < D; k++)  // R7 low phase carries the complement
          push(1, 0, 0, 0, 0, ~rv[b], 7, 0, '0);
      end
      push(0, 1, 0, 0, 0, 1, 10, 1, rv);  // R10 done with new read data
    end else begin
      for (int k = 0; k < D; k++)  // R5 released low phase
        push(1, 0, 0, 0, 0, 1, 5, 0, '0);
      push(0, 1, 0, 0, 0, 1, 10, 0, '0);  // R10
    end
  endtask

  task automatic step();
    exp_t e;
    logic bad;
    @(negedge clk);
    if (q.size() != 0) e = q.pop_front();
    else begin
      e.busy = 0; e.done = 0; e.mdc = 0; e.oe = 0; e.mdo = 0;
      e.din = 1; e.upd = 0; e.rv = '0; e.req = 1;  // R1 idle
    end
    if (e.upd) cur_rd = e.rv;
    bad = (busy_o !== e.busy) || (done_o !== e.done) || (mdc_o !== e.mdc) ||
          (mdio_oe_o !== e.oe) || (e.oe && (mdio_o !== e.mdo)) ||
          (rdata_o !== cur_rd);
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL R%0d t=%0t act busy=%b done=%b mdc=%b oe=%b mdo=%b rd=%h exp busy=%b done=%b mdc=%b oe=%b mdo=%b rd=%h",
               e.req, $time, busy_o, done_o, mdc_o, mdio_oe_o, mdio_o, rdata_o,
               e.busy, e.done, e.mdc, e.oe, e.mdo, cur_rd);
    end
    mdio_i = e.din;
  endtask

  task automatic issue(logic rd, logic [4:0] phy, logic [4:0] rg,
                       logic [15:0] wd, logic [15:0] rv);
    cmd_i = 1; rd_i = rd; phy_addr_i = phy; reg_addr_i = rg; wdata_i = wd;
    if (q.size() == 0) build(rd, phy, rg, wd, rv);  // R9 ignored when busy
    step();
    cmd_i = 0; rd_i = 0; phy_addr_i = '0; reg_addr_i = '0; wdata_i = '0;
  endtask

  task automatic drain();
    while (q.size() != 0) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) step();                               // R1
    issue(0, 5'h11, 5'h0A, 16'hA5C3, '0);            // R2 R3 R5 write
    drain(); repeat (4) step();
    issue(1, 5'h1F, 5'h00, '0, 16'h8001);            // R6 R7 R8 read
    repeat (100) step();
    issue(0, 5'h00, 5'h1F, 16'hFFFF, '0);            // R9 ignored mid-frame
    drain(); repeat (2) step();
    issue(1, 5'h00, 5'h1F, '0, 16'h5A3C);            // R7 read
    drain(); repeat (2) step();
    issue(0, 5'h00, 5'h00, 16'h0000, '0);            // R10 rdata held over write
    drain(); repeat (2) step();
    issue(0, 5'h15, 5'h0A, 16'hFFFF, '0);            // R5 all-ones data
    drain();
    issue(1, 5'h0A, 5'h15, '0, 16'hFFFF);            // R10 back-to-back on done cycle
    drain();
    issue(1, 5'h03, 5'h1C, '0, 16'h0000);            // R7 all-zero read
    drain(); repeat (3) step();
    n_tests++;
    if (rdata_o !== 16'h0000) begin                  // R7 final result
      n_fail++;
      $display("FAIL R7 final rdata act=%h exp=%h", rdata_o, 16'h0000);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule